// File: doc/BRIEF.md
# Dual-Operand Parallel Load Unit

This block sits beside the instruction decoder of a 16-bit signal-processing core. It takes the low byte of an instruction word when that byte carries a parallel dual-load extension. It then issues two data-memory reads in the same cycle. The first read goes through a selectable pointer. The second read always goes through pointer 3. Both words come back within the cycle and leave the block at once as a pair of register-file writes into halves of the two auxiliary accumulators.

The byte supports two load shapes in one encoding space. In the split shape, each read fills a chosen half (low or high) of a different auxiliary register. The paired shape is chosen when the two lowest bits are both set. In that shape, one auxiliary register is filled whole: its high half from the selectable pointer and its low half from pointer 3.

Each of the two pointers is post-updated on its own terms. It either steps by one or adds its own signed index register. The two new pointer values are registered and presented for write-back one cycle after the accepted byte. The two pointers are always different registers, so both updates commit together.

Top module: `dual_load_unit`

## Requirements
- R1: A byte is accepted only when `ext_valid` is 1 and byte bits 7:6 are 11. In that cycle `rd0_en`, `rd1_en`, `wr0_en` and `wr1_en` are all 1. In any other cycle all four are 0, and in the following cycle `ptr_we` is all zero.
- R2: `rd1_addr` always carries the current (pre-update) value of pointer 3. `rd0_addr` carries the current value of the selected pointer S.
- R3: Split shape (bits 1:0 not 11): S equals bits 1:0, giving pointer 0, 1 or 2.
- R4: Split shape destinations: `wr0_idx` = 0x18 + 2*bit5 with `wr0_data` = `rd0_data`, and `wr1_idx` = 0x19 + 2*bit4 with `wr1_data` = `rd1_data`.
- R5: Paired shape (bits 1:0 = 11): S is pointer 0 when bit 5 is 0 and pointer 1 when bit 5 is 1. `wr0_idx` = 0x1A + bit4 (high half) receives `rd0_data`. `wr1_idx` = 0x18 + bit4 (low half) receives `rd1_data`.
- R6: Bit 2 chooses the update of pointer S: 0 gives S+1, 1 gives S + index S.
- R7: Bit 3 chooses the update of pointer 3: 0 gives +1, 1 gives + index 3.
- R8: One cycle after an accepted byte, `ptr_we` has exactly bits S and 3 set. The matching 16-bit lanes of `ptr_wdata` (lane i at bits 16*i+15:16*i) hold the new values. Lanes that are not enabled carry no meaning.
- R9: Pointer arithmetic wraps modulo 2^16, and index registers act as signed two's-complement offsets.
- R10: While reset is asserted, and in the first cycle after it, `ptr_we` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_valid | input | 1 | Extension byte is valid this cycle |
| ext_byte | input | 8 | Low byte of the instruction word |
| addr_regs | input | 64 | Four 16-bit pointers, pointer i in bits 16*i+15:16*i |
| index_regs | input | 64 | Four 16-bit signed index registers, same packing |
| rd0_en | output | 1 | Read enable, selectable-pointer port |
| rd0_addr | output | 16 | Read address, selectable-pointer port |
| rd0_data | input | 16 | Word returned in the same cycle for port 0 |
| rd1_en | output | 1 | Read enable, pointer-3 port |
| rd1_addr | output | 16 | Read address, pointer-3 port |
| rd1_data | input | 16 | Word returned in the same cycle for port 1 |
| wr0_en | output | 1 | Register write enable, lane 0 |
| wr0_idx | output | 5 | Register index, lane 0 |
| wr0_data | output | 16 | Register data, lane 0 |
| wr1_en | output | 1 | Register write enable, lane 1 |
| wr1_idx | output | 5 | Register index, lane 1 |
| wr1_data | output | 16 | Register data, lane 1 |
| ptr_we | output | 4 | Registered pointer write-back enables |
| ptr_wdata | output | 64 | Registered updated pointer values, lane per pointer |

## Verification
The bench uses the default parameters: 16-bit addresses and data, four pointers, and the auxiliary bank at register index 0x18. With these values a pointer at 0xFFFF that steps by one reaches 0x0000. An index of 0xFFFE then pulls a pointer backwards, so both wrap and signed offsets are exercised with literal values. Every split source (0 to 2), every paired source and destination, and all four update modes are driven back to back. A scoreboard queue lines each accepted byte up with the write-back that appears one cycle later.

// File: rtl/dlu_pkg.sv
`timescale 1ns/100ps
// Shared types for the dual-operand parallel load unit.
// Assumes a 5-bit register-file index and a four-pointer address bank.
package dlu_pkg;

    localparam int REG_IDX_W = 5;
    localparam int SEL_W     = 2;

    // Decoded view of one extension byte.
    typedef struct packed {
        logic                 hit;      // byte accepted this cycle
        logic                 paired;   // paired (whole register) shape
        logic [SEL_W-1:0]     s_sel;    // selectable pointer number
        logic                 s_use_ix; // pointer S adds its index
        logic                 t_use_ix; // pointer 3 adds its index
        logic [REG_IDX_W-1:0] dst0;     // destination of port-0 word
        logic [REG_IDX_W-1:0] dst1;     // destination of port-1 word
    } dlu_dec_t;

endpackage

// File: rtl/dlu_decode.sv
`timescale 1ns/100ps
// Decodes the extension byte into source pointer, update modes and
// destination register indices. Purely combinational.
// Assumes the auxiliary bank starts at AX_BASE: low halves at +0/+1,
// high halves at +2/+3.
module dlu_decode
    import dlu_pkg::*;
#(
    parameter logic [REG_IDX_W-1:0] AX_BASE = 5'h18
) (
    input  logic     valid,
    input  logic [7:0] ext,
    output dlu_dec_t dec
);

    localparam logic [REG_IDX_W-1:0] LO0 = AX_BASE;
    localparam logic [REG_IDX_W-1:0] LO1 = AX_BASE + 5'd1;
    localparam logic [REG_IDX_W-1:0] HI0 = AX_BASE + 5'd2;
    localparam logic [REG_IDX_W-1:0] HI1 = AX_BASE + 5'd3;

    // Split the byte into its fields and pick the load shape.
    always_comb begin
        dec          = '0;
        dec.hit      = valid && (ext[7:6] == 2'b11);
        dec.paired   = (ext[1:0] == 2'b11);
        dec.s_use_ix = ext[2];
        dec.t_use_ix = ext[3];
        if (dec.paired) begin
            dec.s_sel = {1'b0, ext[5]};
            dec.dst0  = ext[4] ? HI1 : HI0;
            dec.dst1  = ext[4] ? LO1 : LO0;
        end else begin
            dec.s_sel = ext[1:0];
            dec.dst0  = ext[5] ? HI0 : LO0;
            dec.dst1  = ext[4] ? HI1 : LO1;
        end
    end

endmodule

// File: rtl/dlu_ptr_step.sv
`timescale 1ns/100ps
// Computes the post-update value of one pointer: either a step of one
// or the addition of its signed index. Wraps modulo 2^W.
module dlu_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] idx,
    input  logic         use_ix,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    // Choose the increment and add it with natural wrap.
    always_comb begin
        nxt = cur + (use_ix ? idx : ONE);
    end

endmodule

// File: rtl/dlu_ptr_wb.sv
`timescale 1ns/100ps
// Registers the two updated pointer values and their per-pointer write
// enables for write-back one cycle after an accepted byte.
// Assumes the fixed second pointer is the last one (N-1) and that the
// selectable pointer never equals it.
module dlu_ptr_wb #(
    parameter int W     = 16,
    parameter int N     = 4,
    parameter int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [SEL_W-1:0] s_sel,
    input  logic [W-1:0]     s_next,
    input  logic [W-1:0]     t_next,
    output logic [N-1:0]     we,
    output logic [N*W-1:0]   wdata
);

    localparam int T_LANE = N - 1;

    for (genvar i = 0; i < N; i++) begin : g_lane
        // Latch the new value for this lane when it is one of the two targets.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                we[i]            <= 1'b0;
                wdata[i*W +: W]  <= '0;
            end else if (i == T_LANE) begin
                we[i]            <= hit;
                wdata[i*W +: W]  <= t_next;
            end else begin
                we[i]            <= hit && (s_sel == SEL_W'(i));
                wdata[i*W +: W]  <= s_next;
            end
        end
    end

    assert_wb_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ($countones(we) == 2) && we[T_LANE]);

    assert_wb_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (we == '0));

endmodule

// File: rtl/dual_load_unit.sv
`timescale 1ns/100ps
// Dual-operand parallel load unit. Decodes a load extension byte, drives
// two same-cycle memory reads (selectable pointer and pointer N-1),
// forwards the returned words as two register-file writes and registers
// the post-updated pointers for write-back.
// Assumes memory returns read data combinationally in the same cycle.
module dual_load_unit
    import dlu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_PTR = 4,
    parameter logic [REG_IDX_W-1:0] AX_BASE = 5'h18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ext_valid,
    input  logic [7:0]                ext_byte,
    input  logic [NUM_PTR*ADDR_W-1:0] addr_regs,
    input  logic [NUM_PTR*ADDR_W-1:0] index_regs,
    output logic                      rd0_en,
    output logic [ADDR_W-1:0]         rd0_addr,
    input  logic [DATA_W-1:0]         rd0_data,
    output logic                      rd1_en,
    output logic [ADDR_W-1:0]         rd1_addr,
    input  logic [DATA_W-1:0]         rd1_data,
    output logic                      wr0_en,
    output logic [REG_IDX_W-1:0]      wr0_idx,
    output logic [DATA_W-1:0]         wr0_data,
    output logic                      wr1_en,
    output logic [REG_IDX_W-1:0]      wr1_idx,
    output logic [DATA_W-1:0]         wr1_data,
    output logic [NUM_PTR-1:0]        ptr_we,
    output logic [NUM_PTR*ADDR_W-1:0] ptr_wdata
);

    localparam int T_PTR = NUM_PTR - 1;
    localparam int LANES = 2;

    dlu_dec_t          dec;
    logic [ADDR_W-1:0] cur  [LANES];
    logic [ADDR_W-1:0] ofs  [LANES];
    logic              useo [LANES];
    logic [ADDR_W-1:0] nxt  [LANES];

    dlu_decode #(.AX_BASE(AX_BASE)) u_dec (
        .valid (ext_valid),
        .ext   (ext_byte),
        .dec   (dec)
    );

    // Gather the pre-update pointer, index and mode for each read lane.
    always_comb begin
        cur[0]  = addr_regs [dec.s_sel*ADDR_W +: ADDR_W];
        ofs[0]  = index_regs[dec.s_sel*ADDR_W +: ADDR_W];
        useo[0] = dec.s_use_ix;
        cur[1]  = addr_regs [T_PTR*ADDR_W +: ADDR_W];
        ofs[1]  = index_regs[T_PTR*ADDR_W +: ADDR_W];
        useo[1] = dec.t_use_ix;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_step
        dlu_ptr_step #(.W(ADDR_W)) u_step (
            .cur    (cur[k]),
            .idx    (ofs[k]),
            .use_ix (useo[k]),
            .nxt    (nxt[k])
        );
    end

    // Drive both read ports and forward their words to the register file.
    always_comb begin
        rd0_en   = dec.hit;
        rd1_en   = dec.hit;
        rd0_addr = cur[0];
        rd1_addr = cur[1];
        wr0_en   = dec.hit;
        wr1_en   = dec.hit;
        wr0_idx  = dec.dst0;
        wr1_idx  = dec.dst1;
        wr0_data = rd0_data;
        wr1_data = rd1_data;
    end

    dlu_ptr_wb #(.W(ADDR_W), .N(NUM_PTR)) u_wb (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (dec.hit),
        .s_sel  (dec.s_sel),
        .s_next (nxt[0]),
        .t_next (nxt[1]),
        .we     (ptr_we),
        .wdata  (ptr_wdata)
    );

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_valid && ext_byte[7:6] == 2'b11) |->
            !rd0_en && !rd1_en && !wr0_en && !wr1_en);

    assert_fixed_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_en |-> rd1_addr == addr_regs[T_PTR*ADDR_W +: ADDR_W]);

    assert_dst_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr0_en |-> wr0_idx != wr1_idx);

    assert_paired_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_en && ext_byte[1:0] == 2'b11) |->
            (rd0_addr == addr_regs[0 +: ADDR_W] ||
             rd0_addr == addr_regs[ADDR_W +: ADDR_W]));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> ptr_we == '0);

endmodule

// File: tb/sim_dual_load_unit.sv
`timescale 1ns/100ps
module sim_dual_load_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_valid = 1'b0;
    logic [7:0]  ext_byte = '0;
    logic [15:0] ar [4];
    logic [15:0] ix [4];
    logic [63:0] addr_regs, index_regs;
    logic        rd0_en, rd1_en, wr0_en, wr1_en;
    logic [15:0] rd0_addr, rd1_addr, rd0_data, rd1_data, wr0_data, wr1_data;
    logic [4:0]  wr0_idx, wr1_idx;
    logic [3:0]  ptr_we;
    logic [63:0] ptr_wdata;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed {
        logic [3:0]  we;
        logic [1:0]  s;
        logic [15:0] ns;
        logic [15:0] nt;
    } wb_item_t;
    wb_item_t exp_q[$];

    always #2 clk = ~clk;

    assign addr_regs  = {ar[3], ar[2], ar[1], ar[0]};
    assign index_regs = {ix[3], ix[2], ix[1], ix[0]};
    // memory model: distinct data per port
    assign rd0_data = rd0_addr ^ 16'h5A5A;
    assign rd1_data = rd1_addr + 16'h1234;

    dual_load_unit u0 (
        .clk(clk), .rst_n(rst_n), .ext_valid(ext_valid), .ext_byte(ext_byte),
        .addr_regs(addr_regs), .index_regs(index_regs),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: apply one byte, check same-cycle outputs, queue write-back.
    task automatic op(input logic v, input logic [7:0] b, input string req);
        logic hit, paired;
        logic [1:0] s;
        logic [15:0] a0, a1;
        logic [4:0] i0, i1;
        wb_item_t it;
        @(posedge clk);
        #0.5;
        ext_valid = v;
        ext_byte  = b;
        hit    = v && (b[7:6] == 2'b11);
        paired = (b[1:0] == 2'b11);
        s  = paired ? {1'b0, b[5]} : b[1:0];
        a0 = ar[s];
        a1 = ar[3];
        i0 = paired ? (5'h1A + 5'(b[4])) : (5'h18 + 5'({b[5], 1'b0}));
        i1 = paired ? (5'h18 + 5'(b[4])) : (5'h19 + 5'({b[4], 1'b0}));
        it.we = hit ? (4'b1000 | (4'b0001 << s)) : 4'b0000;
        it.s  = s;
        it.ns = b[2] ? a0 + ix[s] : a0 + 16'd1;
        it.nt = b[3] ? a1 + ix[3] : a1 + 16'd1;
        #1;
        chk({req, " R1 rd0_en"}, 64'(rd0_en), 64'(hit));
        chk({req, " R1 rd1_en"}, 64'(rd1_en), 64'(hit));
        chk({req, " R1 wr0_en"}, 64'(wr0_en), 64'(hit));
        chk({req, " R1 wr1_en"}, 64'(wr1_en), 64'(hit));
        if (hit) begin
            chk({req, " R2 rd0_addr"}, 64'(rd0_addr), 64'(a0));
            chk({req, " R2 rd1_addr"}, 64'(rd1_addr), 64'(a1));
            chk({req, " R4/R5 wr0_idx"}, 64'(wr0_idx), 64'(i0));
            chk({req, " R4/R5 wr1_idx"}, 64'(wr1_idx), 64'(i1));
            chk({req, " R4/R5 wr0_data"}, 64'(wr0_data), 64'(a0 ^ 16'h5A5A));
            chk({req, " R4/R5 wr1_data"}, 64'(wr1_data), 64'(a1 + 16'h1234));
        end
        exp_q.push_back(it);
    endtask

    // Monitor: one cycle after each driven byte, compare registered write-back.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                wb_item_t e;
                e = exp_q.pop_front();
                chk("R8 ptr_we", 64'(ptr_we), 64'(e.we));
                if (e.we != 4'b0000) begin
                    chk("R6/R9 new pointer S", 64'(ptr_wdata[e.s*16 +: 16]), 64'(e.ns));
                    chk("R7/R9 new pointer 3", 64'(ptr_wdata[48 +: 16]), 64'(e.nt));
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        ar[0] = 16'h1000; ar[1] = 16'h2000; ar[2] = 16'h3000; ar[3] = 16'h4000;
        ix[0] = 16'h0010; ix[1] = 16'h0020; ix[2] = 16'h0030; ix[3] = 16'h0040;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 ptr_we in reset", 64'(ptr_we), 64'd0);
        @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        #1;
        chk("R10 ptr_we after reset", 64'(ptr_we), 64'd0);

        // split shapes, each source and each update mode (R3, R4, R6, R7)
        op(1'b1, 8'b1100_0000, "split S0 D0 R0 mode00 R3");
        op(1'b1, 8'b1111_0110, "split S2 D1 R1 mode01 R3");
        op(1'b1, 8'b1110_1001, "split S1 D1 R0 mode10 R3");
        op(1'b1, 8'b1101_1110, "split S2 D0 R1 mode11 R6 R7");
        // paired shapes (R5)
        op(1'b1, 8'b1100_0011, "paired ar0 ax0 mode00 R5");
        op(1'b1, 8'b1111_1111, "paired ar1 ax1 mode11 R5");
        op(1'b1, 8'b1101_0111, "paired ar0 ax1 mode01 R5");
        op(1'b1, 8'b1110_1011, "paired ar1 ax0 mode10 R5");
        // rejected bytes (R1)
        op(1'b0, 8'b1100_0000, "valid low R1");
        op(1'b1, 8'b1000_0000, "bits7:6=10 R1");
        op(1'b1, 8'b0111_1111, "bits7:6=01 R1");

        // wrap and negative index (R9)
        @(posedge clk);
        #0.5;
        ar[1] = 16'hFFFF; ar[3] = 16'h0001;
        ix[1] = 16'h0005; ix[3] = 16'hFFFE;
        op(1'b1, 8'b1100_1001, "wrap inc, negative ix R9");
        op(1'b1, 8'b1100_0101, "wrap add ix R9");
        op(1'b1, 8'b1110_0011, "paired wrap R9");
        op(1'b0, 8'h00, "idle R1");
        repeat (3) @(posedge clk);
        #2;
        chk("R8 queue drained", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule